// File: doc/BRIEF.md
# Secret Key Input Loader

This block sits on the secret-data side of an authenticated cipher. It takes a stream of 32-bit words over a valid/ready handshake. That bus carries nothing but key material and never shares a path with public data. A stream starts with an instruction word that must carry the load-key opcode. A key-typed segment header follows, and then the key words. The block collects those words into a staging register and raises a flag saying a fresh key is waiting.

The cipher's working key is a separate register. It changes only when the public-data parser asks for key activation. The block then copies the staged key into the working key, one word per cycle. While that copy runs, the secret bus is stalled, so the key being copied cannot be overwritten. Malformed instructions or headers raise a sticky error flag. A header with the wrong length also makes the block skip the payload it announces.

Top module: `keyin_loader`

## Requirements
- R1: After reset `sdi_ready` is 1, and `key_pending`, `load_err`, `act_busy` and `active_key` are all 0.
- R2: A word is consumed only on a clock edge where `sdi_valid` and `sdi_ready` are both 1. Idle cycles between words of any length do not change the result.
- R3: The first word of a stream is the instruction. Its bits [31:28] must equal 4'b0100. Any other value discards that word, sets `load_err`, and the block keeps waiting for an instruction.
- R4: The word after the instruction is a segment header. Bits [31:28] = 4'b1100 with bits [15:0] = 16 (bytes) is followed by four key words. These fill the 128-bit key with the most significant word first.
- R5: A key header whose length is not 16 sets `load_err` and discards the following ceil(length/4) words. `key_pending` stays 0. A length of 0 returns straight to waiting for an instruction.
- R6: A header whose bits [31:28] are not 4'b1100 sets `load_err` and returns to waiting for an instruction.
- R7: `key_pending` goes to 1 on the edge that accepts the last key word. It clears when an activation copy completes.
- R8: When `act_req` is 1 while a key is pending, `sdi_ready` drops in that same cycle. `act_busy` is then 1 for exactly 4 cycles, `sdi_ready` is 0 throughout, and afterwards `active_key` equals the staged key.
- R9: `act_req` with no pending key does not start a copy and leaves `active_key` unchanged. `active_key` never changes outside an activation copy.
- R10: `load_err` stays set until the next accepted load-key instruction word, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sdi_word | input | 32 | Secret data word |
| sdi_valid | input | 1 | Source has a word on `sdi_word` |
| sdi_ready | output | 1 | Block can accept a word this cycle |
| act_req | input | 1 | Key activation request from the public-data parser |
| key_pending | output | 1 | A complete key is staged and not yet activated |
| load_err | output | 1 | Sticky flag for a malformed instruction or header |
| act_busy | output | 1 | Activation copy in progress |
| active_key | output | 128 | Key presented to the cipher |

## Verification
The bench builds the block with its default 32-bit word and four-word key. With those values every header length from 0 to 24 bytes and every one of the 16 opcode and segment-type codes can be swept. Each wrong length is followed by a payload of instruction-shaped words. A skip count that is off by one word would therefore be caught, because the next stream would be misread. Keys derived arithmetically from a sweep index are loaded with varying idle gaps and compared after each activation.

// File: rtl/keyin_loader.sv
module keyin_loader #(
  parameter int WORD_W = 32,
  parameter int KEY_WORDS = 4,
  parameter logic [3:0] OP_LOAD = 4'b0100,
  parameter logic [3:0] SEG_KEY = 4'b1100
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WORD_W-1:0]           sdi_word,
  input  logic                        sdi_valid,
  output logic                        sdi_ready,
  input  logic                        act_req,
  output logic                        key_pending,
  output logic                        load_err,
  output logic                        act_busy,
  output logic [WORD_W*KEY_WORDS-1:0] active_key
);
  localparam int KEY_W = WORD_W * KEY_WORDS;
  localparam int KEY_BYTES = KEY_W / 8;
  localparam int CW = $clog2(KEY_WORDS + 1);
  localparam int LEN_W = 16;

  typedef enum logic [1:0] {ST_OP, ST_HDR, ST_KEY, ST_SKIP} st_t;
  st_t st;

  logic [KEY_W-1:0] stash;
  logic [CW-1:0]    wcnt, ccnt;
  logic [LEN_W-1:0] skip_left;
  int               sel;

  wire              act_go = act_req && key_pending && !act_busy;
  assign sdi_ready = !act_busy && !act_go;
  wire              take = sdi_valid && sdi_ready;
  wire [3:0]        top4 = sdi_word[WORD_W-1 -: 4];
  wire [LEN_W-1:0]  len  = sdi_word[LEN_W-1:0];
  wire [LEN_W:0]    len_up = {1'b0, len} + (LEN_W+1)'(3);
  wire [LEN_W-1:0]  nwords = len_up[LEN_W:2];

  always_comb sel = (KEY_WORDS - 1 - int'(ccnt)) * WORD_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_OP;
      stash       <= '0;
      wcnt        <= '0;
      ccnt        <= '0;
      skip_left   <= '0;
      key_pending <= 1'b0;
      load_err    <= 1'b0;
      act_busy    <= 1'b0;
      active_key  <= '0;
    end else begin
      if (take) begin
        case (st)
          ST_OP:
            if (top4 == OP_LOAD) begin
              load_err <= 1'b0;
              st       <= ST_HDR;
            end else load_err <= 1'b1;
          ST_HDR:
            if (top4 != SEG_KEY) begin
              load_err <= 1'b1;
              st       <= ST_OP;
            end else if (len == LEN_W'(KEY_BYTES)) begin
              wcnt <= '0;
              st   <= ST_KEY;
            end else begin
              load_err <= 1'b1;
              if (nwords == '0) st <= ST_OP;
              else begin
                skip_left <= nwords;
                st        <= ST_SKIP;
              end
            end
          ST_KEY: begin
            stash       <= {stash[KEY_W-WORD_W-1:0], sdi_word};
            key_pending <= (wcnt == CW'(KEY_WORDS - 1));
            wcnt        <= wcnt + 1'b1;
            if (wcnt == CW'(KEY_WORDS - 1)) st <= ST_OP;
          end
          default: begin
            skip_left <= skip_left - 1'b1;
            if (skip_left == LEN_W'(1)) st <= ST_OP;
          end
        endcase
      end
      if (act_go) begin
        act_busy <= 1'b1;
        ccnt     <= '0;
      end else if (act_busy) begin
        active_key[sel +: WORD_W] <= stash[sel +: WORD_W];
        ccnt <= ccnt + 1'b1;
        if (ccnt == CW'(KEY_WORDS - 1)) begin
          act_busy    <= 1'b0;
          key_pending <= 1'b0;
        end
      end
    end
  end

  p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_busy |-> !sdi_ready);
  p_key_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_busy |=> $stable(active_key));
  p_no_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req && !key_pending && !act_busy) |=> !act_busy);
  p_pending_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_pending) |-> $past(take && st == ST_KEY));
  p_err_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_err) |-> $past(take && st == ST_OP));
endmodule

// File: tb/sim_keyin_loader.sv
module sim_keyin_loader;
  logic clk = 0, rst_n = 0, sdi_valid = 0, act_req = 0;
  logic [31:0] sdi_word = '0;
  logic sdi_ready, key_pending, load_err, act_busy;
  logic [127:0] active_key;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  keyin_loader u0 (.clk(clk), .rst_n(rst_n), .sdi_word(sdi_word), .sdi_valid(sdi_valid),
    .sdi_ready(sdi_ready), .act_req(act_req), .key_pending(key_pending), .load_err(load_err),
    .act_busy(act_busy), .active_key(active_key));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] kw(input int k, input int i);
    return (32'h9E3779B9 * (k + 1)) ^ (32'h01000193 * (i + 7));
  endfunction

  function automatic logic [127:0] kexp(input int k);
    return {kw(k, 0), kw(k, 1), kw(k, 2), kw(k, 3)};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic send(input logic [31:0] w, input int gap);
    logic acc;
    idle(gap);
    sdi_word = w; sdi_valid = 1;
    forever begin
      #1 acc = sdi_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    sdi_valid = 0;
  endtask

  task automatic load_key(input int k, input int gap);
    send({4'b0100, 28'h0}, gap);
    send({4'b1100, 12'h0, 16'd16}, gap);
    for (int i = 0; i < 4; i++) send(kw(k, i), gap);
  endtask

  task automatic activate(input logic [127:0] exp);
    int n;
    act_req = 1;
    #1 chk("R8 ready drop on request", 128'(sdi_ready), 128'(0));
    @(posedge clk); #1;
    act_req = 0;
    chk("R8 busy", 128'(act_busy), 128'(1));
    n = 0;
    while (act_busy && n < 20) begin
      chk("R8 ready low while busy", 128'(sdi_ready), 128'(0));
      @(posedge clk); #1; n++;
    end
    chk("R8 copy cycles", 128'(n), 128'(4));
    chk("R8 active key", active_key, exp);
    chk("R7 pending cleared", 128'(key_pending), 128'(0));
  endtask

  initial begin
    idle(3);
    chk("R1 ready", 128'(sdi_ready), 128'(1));
    chk("R1 pending", 128'(key_pending), 128'(0));
    chk("R1 err", 128'(load_err), 128'(0));
    chk("R1 busy", 128'(act_busy), 128'(0));
    chk("R1 key", active_key, 128'(0));
    rst_n = 1;
    idle(1);

    for (int k = 0; k < 6; k++) begin
      load_key(k, k % 3);
      chk("R7 pending set", 128'(key_pending), 128'(1));
      chk("R2 R4 no error", 128'(load_err), 128'(0));
      idle(k % 2);
      activate(kexp(k));
    end

    act_req = 1; @(posedge clk); #1; act_req = 0;
    chk("R9 no copy started", 128'(act_busy), 128'(0));
    idle(6);
    chk("R9 key unchanged", active_key, kexp(5));

    for (int op = 0; op < 16; op++) begin
      if (op == 4) continue;
      send({op[3:0], 28'h5A5A5A5}, 0);
      chk("R3 bad opcode err", 128'(load_err), 128'(1));
      chk("R3 no pending", 128'(key_pending), 128'(0));
      send({4'b0100, 28'h0}, 0);
      chk("R10 err cleared", 128'(load_err), 128'(0));
      send({4'b1100, 12'h0, 16'd16}, 0);
      for (int i = 0; i < 4; i++) send(kw(op + 10, i), 0);
      activate(kexp(op + 10));
    end

    for (int t = 0; t < 16; t++) begin
      if (t == 12) continue;
      send({4'b0100, 28'h0}, 0);
      send({t[3:0], 12'h0, 16'd16}, 0);
      chk("R6 bad type err", 128'(load_err), 128'(1));
      load_key(t + 40, 1);
      chk("R6 recovery pending", 128'(key_pending), 128'(1));
      activate(kexp(t + 40));
    end

    for (int len = 0; len < 25; len++) begin
      if (len == 16) continue;
      send({4'b0100, 28'h0}, 0);
      send({4'b1100, 12'h0, 16'(len)}, 0);
      chk("R5 bad length err", 128'(load_err), 128'(1));
      for (int i = 0; i < (len + 3) / 4; i++) send({4'b0100, 28'h0}, 0);
      chk("R5 no pending", 128'(key_pending), 128'(0));
      chk("R5 still err after skip", 128'(load_err), 128'(1));
      load_key(len + 70, 0);
      chk("R5 recovery pending", 128'(key_pending), 128'(1));
      activate(kexp(len + 70));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule